// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes the eight shared PCI interrupt request levels (lines A to H, already folded from every slot's INTx pins) and presents them on 24 global system interrupt (GSI) outputs at once. GSI 0 to 15 serve a legacy 8259-style controller. Each of these is driven by whichever request lines software has steered to it. GSI 16 to 23 serve an I/O APIC, with line A on GSI 16 through line H on GSI 23, fixed and never shared. Both views are live together, so software can switch interrupt models without touching this block.

A power-management SCI level is merged onto one GSI chosen by a select code. The choice can be one of the legacy pins 9, 10 or 11, or one of the APIC pins 20 or 21. When software retargets the SCI while it is asserted, a two-state machine (STEADY, RELEASE) first removes the SCI from the old pin for one cycle and then places it on the new pin. Two pins therefore never carry it together. States and transitions: STEADY stays in STEADY on any cycle with no effective retarget, and also when the SCI is low and the retarget is applied at once. STEADY goes to RELEASE when a valid select names a different GSI while the latched SCI is high. RELEASE always returns to STEADY on the next clock and commits the new target.

Software programs the routes through a byte-wide write port. All GSI outputs are registered.

Top module: `pirq_router`

## Requirements
- R1: After reset, every route byte holds 8'h80 (disabled), the SCI target is GSI 9, the latched SCI is low and all GSI outputs are 0.
- R2: A route byte holds the target legacy pin in bits [6:0] and a disable flag in bit 7. Legacy GSI n (0..15) is high when at least one line is high, has its disable flag clear and has target n.
- R3: Several enabled lines steered to the same legacy pin are ORed together on that pin.
- R4: A line with its disable flag set, or with a target of 16 or more, drives no legacy pin.
- R5: Line k (A=0 .. H=7, pirq_in bit k) drives GSI 16+k whatever its route byte holds.
- R6: Write address map: lines A to D at addresses 0 to 3, SCI select at address 4, lines E to H at addresses 8 to 11. Writes to any other address change nothing.
- R7: The SCI select code is cfg_wdata[2:0]: 0 selects GSI 9, 1 selects 10, 2 selects 11, 4 selects 20, 5 selects 21. The latched SCI level is ORed onto the selected GSI.
- R8: Select codes 3, 6 and 7 are reserved and leave the SCI target unchanged.
- R9: When the target changes while the latched SCI is high, the old GSI drops one clock after the write edge and the new GSI rises one clock after that. The SCI never appears on two GSIs in the same cycle.
- R10: GSI outputs are registered. They follow pirq_in as sampled at a clock edge, and follow a route write or an SCI level change one clock after the edge that captured it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pirq_in | input | 8 | Interrupt request levels, bit k = line k (A..H) |
| sci_in | input | 1 | Power-management SCI level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| gsi_out | output | 24 | GSI levels: 0..15 legacy, 16..23 APIC |

## Verification
The bench moves an asserted SCI between targets and samples the write edge, the gap cycle and the settle cycle. A router that switches the target directly would show both pins high or no gap, and one that forgets the move would leave the old pin high. It writes reserved select codes and checks that the SCI stays on its pin; a decoder that maps them to some default would move it. It steers lines to a shared pin, disables one and gives another an out-of-range target. A router that drops the disable flag or truncates the target to four bits would light an extra legacy pin. It also writes to unmapped addresses that alias onto live registers when address bits are dropped, and a mid-run reset must bring the disabled defaults back.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    typedef enum logic {
        ST_STEADY  = 1'b0,
        ST_RELEASE = 1'b1
    } sci_state_e;

    typedef struct packed {
        logic       ok;
        logic [4:0] gsi;
    } sci_dec_t;

    // Select code to SCI GSI; reserved codes report ok = 0.
    function automatic sci_dec_t decode_sci(input logic [2:0] code);
        sci_dec_t d;
        d.ok  = 1'b1;
        d.gsi = 5'd9;
        unique case (code)
            3'd0: d.gsi = 5'd9;
            3'd1: d.gsi = 5'd10;
            3'd2: d.gsi = 5'd11;
            3'd4: d.gsi = 5'd20;
            3'd5: d.gsi = 5'd21;
            default: d.ok = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
    parameter int         N_PIRQ    = 8,
    parameter int         ADDR_W    = 4,
    parameter int         GRP_SIZE  = 4,
    parameter int         GRP0_BASE = 0,
    parameter int         GRP1_BASE = 8,
    parameter int         SCI_ADDR  = 4,
    parameter logic [7:0] ROUTE_RST = 8'h80
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [7:0]             cfg_wdata,
    output logic [N_PIRQ-1:0][7:0] route_q,
    output logic                   sel_wr,
    output logic [2:0]             sel_code
);

    logic [N_PIRQ-1:0] hit;

    for (genvar k = 0; k < N_PIRQ; k++) begin : g_route
        localparam int ADDR_K = (k < GRP_SIZE) ? (GRP0_BASE + k)
                                               : (GRP1_BASE + k - GRP_SIZE);
        assign hit[k] = cfg_we && (cfg_addr == ADDR_W'(ADDR_K));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route_q[k] <= ROUTE_RST;
            end else if (hit[k]) begin
                route_q[k] <= cfg_wdata;
            end
        end
    end

    assign sel_wr   = cfg_we && (cfg_addr == ADDR_W'(SCI_ADDR));
    assign sel_code = cfg_wdata[2:0];

endmodule

// File: rtl/pirq_sci_ctl.sv
module pirq_sci_ctl
    import pirq_pkg::*;
#(
    parameter int         GSI_W   = 5,
    parameter logic [4:0] RST_GSI = 5'd9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sci_in,
    input  logic             sel_wr,
    input  logic [2:0]       sel_code,
    output logic             sci_on,
    output logic [GSI_W-1:0] sci_tgt
);

    sci_state_e       st_q, st_n;
    logic [GSI_W-1:0] tgt_q, tgt_n, pend_q, pend_n;
    logic             sci_lat;
    sci_dec_t         dec;
    logic             live_q;

    assign dec = decode_sci(sel_code);

    // State register and the target/level state it carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_STEADY;
            tgt_q   <= GSI_W'(RST_GSI);
            pend_q  <= GSI_W'(RST_GSI);
            sci_lat <= 1'b0;
            live_q  <= 1'b0;
        end else begin
            st_q    <= st_n;
            tgt_q   <= tgt_n;
            pend_q  <= pend_n;
            sci_lat <= sci_in;
            live_q  <= 1'b1;
        end
    end

    // Next state.
    always_comb begin
        st_n   = st_q;
        tgt_n  = tgt_q;
        pend_n = pend_q;
        unique case (st_q)
            ST_STEADY: begin
                if (sel_wr && dec.ok && (GSI_W'(dec.gsi) != tgt_q)) begin
                    if (sci_lat) begin
                        pend_n = GSI_W'(dec.gsi);
                        st_n   = ST_RELEASE;
                    end else begin
                        tgt_n  = GSI_W'(dec.gsi);
                    end
                end
            end
            ST_RELEASE: begin
                tgt_n = (sel_wr && dec.ok) ? GSI_W'(dec.gsi) : pend_q;
                st_n  = ST_STEADY;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        sci_on  = 1'b0;
        sci_tgt = tgt_q;
        unique case (st_q)
            ST_STEADY:  sci_on = sci_lat;
            ST_RELEASE: sci_on = 1'b0;
        endcase
    end

    assert_release_one_cycle_R9: assert property (@(posedge clk)
        disable iff (!rst_n || !live_q)
        (st_q == ST_RELEASE) |=> (st_q == ST_STEADY));

    assert_no_move_while_on_R9: assert property (@(posedge clk)
        disable iff (!rst_n || !live_q)
        (sci_on && $past(sci_on)) |-> (sci_tgt == $past(sci_tgt)));

    assert_reserved_keeps_target_R8: assert property (@(posedge clk)
        disable iff (!rst_n || !live_q)
        (sel_wr && !dec.ok && st_q == ST_STEADY) |=> $stable(tgt_q));

endmodule

// File: rtl/pirq_gsi_merge.sv
module pirq_gsi_merge #(
    parameter int N_PIRQ   = 8,
    parameter int N_LEGACY = 16,
    parameter int GSI_W    = 5,
    localparam int N_GSI   = N_LEGACY + N_PIRQ
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PIRQ-1:0]      pirq,
    input  logic [N_PIRQ-1:0][7:0] route_q,
    input  logic                   sci_on,
    input  logic [GSI_W-1:0]       sci_tgt,
    output logic [N_GSI-1:0]       gsi_q
);

    logic [N_GSI-1:0]  gsi_n;
    logic [N_PIRQ-1:0] leg_en;
    logic              live_q;

    for (genvar k = 0; k < N_PIRQ; k++) begin : g_en
        assign leg_en[k] = pirq[k] && !route_q[k][7];
    end

    always_comb begin
        gsi_n = '0;
        for (int n = 0; n < N_LEGACY; n++) begin
            for (int k = 0; k < N_PIRQ; k++) begin
                if (leg_en[k] && (route_q[k][6:0] == 7'(n))) begin
                    gsi_n[n] = 1'b1;
                end
            end
        end
        for (int k = 0; k < N_PIRQ; k++) begin
            gsi_n[N_LEGACY + k] = pirq[k];
        end
        for (int n = 0; n < N_GSI; n++) begin
            if (sci_on && (sci_tgt == GSI_W'(n))) begin
                gsi_n[n] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gsi_q  <= '0;
            live_q <= 1'b0;
        end else begin
            gsi_q  <= gsi_n;
            live_q <= 1'b1;
        end
    end

    for (genvar k = 0; k < N_PIRQ; k++) begin : g_chk
        assert_apic_follows_R5: assert property (@(posedge clk)
            disable iff (!rst_n || !live_q)
            $past(pirq[k]) |-> gsi_q[N_LEGACY + k]);
    end

    assert_legacy_has_source_R2: assert property (@(posedge clk)
        disable iff (!rst_n || !live_q)
        (|gsi_q[N_LEGACY-1:0]) |->
            $past((|leg_en) || (sci_on && (sci_tgt < GSI_W'(N_LEGACY)))));

endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
    parameter int N_PIRQ   = 8,
    parameter int N_LEGACY = 16,
    parameter int ADDR_W   = 4,
    localparam int N_GSI   = N_LEGACY + N_PIRQ,
    localparam int GSI_W   = $clog2(N_GSI)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PIRQ-1:0] pirq_in,
    input  logic              sci_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [N_GSI-1:0]  gsi_out
);

    logic [N_PIRQ-1:0][7:0] route_q;
    logic                   sel_wr;
    logic [2:0]             sel_code;
    logic                   sci_on;
    logic [GSI_W-1:0]       sci_tgt;

    pirq_route_regs #(
        .N_PIRQ (N_PIRQ),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .route_q  (route_q),
        .sel_wr   (sel_wr),
        .sel_code (sel_code)
    );

    pirq_sci_ctl #(
        .GSI_W (GSI_W)
    ) u_sci (
        .clk     (clk),
        .rst_n   (rst_n),
        .sci_in  (sci_in),
        .sel_wr  (sel_wr),
        .sel_code(sel_code),
        .sci_on  (sci_on),
        .sci_tgt (sci_tgt)
    );

    pirq_gsi_merge #(
        .N_PIRQ  (N_PIRQ),
        .N_LEGACY(N_LEGACY),
        .GSI_W   (GSI_W)
    ) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pirq   (pirq_in),
        .route_q(route_q),
        .sci_on (sci_on),
        .sci_tgt(sci_tgt),
        .gsi_q  (gsi_out)
    );

endmodule

// File: tb/pirq_router_tb.sv
module pirq_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pirq_in = '0;
    logic        sci_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [23:0] gsi_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pirq_router u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pirq_in  (pirq_in),
        .sci_in   (sci_in),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .gsi_out  (gsi_out)
    );

    // {pirq_in, expected gsi_out} under the routing set up below:
    // A->5, B->5, C disabled, D->11, E->3, F->15, G->0, H target 16.
    localparam int N_VEC = 11;
    localparam logic [31:0] VEC [N_VEC] = '{
        32'h01_010020,  // R2 A to pin 5
        32'h02_020020,  // R2 B to pin 5
        32'h03_030020,  // R3 shared pin 5
        32'h04_040000,  // R4 C disabled
        32'h08_080800,  // R2 D to pin 11
        32'h10_100008,  // R2 E to pin 3
        32'h20_208000,  // R2 F to pin 15
        32'h40_400001,  // R2 G to pin 0
        32'h80_800000,  // R4 H target 16, no legacy pin
        32'hFF_FF8829,  // R5 all lines
        32'h00_000000   // R10 all low
    };

    task automatic check(input string req, input logic [23:0] exp);
        n_tests++;
        if (gsi_out !== exp) begin
            n_fail++;
            $display("FAIL %s: gsi_out=%06h expected %06h", req, gsi_out, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle;
        @(posedge clk); #1;
    endtask

    task automatic apply(input logic [7:0] p);
        @(negedge clk);
        pirq_in = p;
        settle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 gsi low in reset", 24'h0);
        @(negedge clk) rst_n = 1'b1;
        settle();
        check("R1 gsi low after reset", 24'h0);

        apply(8'hFF);
        check("R1 R5 defaults disabled, APIC only", 24'hFF0000);
        apply(8'h00);

        wr(4'd0, 8'h05); wr(4'd1, 8'h05); wr(4'd2, 8'h8A); wr(4'd3, 8'h0B);
        wr(4'd8, 8'h03); wr(4'd9, 8'h0F); wr(4'd10, 8'h00); wr(4'd11, 8'h10);

        for (int i = 0; i < N_VEC; i++) begin
            apply(VEC[i][31:24]);
            check($sformatf("R2 R3 R4 R5 vector %0d", i), VEC[i][23:0]);
        end

        // R10: a route write shows one clock after its capture edge
        apply(8'h01);
        wr(4'd0, 8'h07);
        check("R10 old route at write edge", 24'h010020);
        settle();
        check("R10 new route one clock later", 24'h010080);
        wr(4'd0, 8'h05);
        apply(8'h00);

        // R6: unmapped addresses, several aliasing live registers
        wr(4'd15, 8'h00); wr(4'd7, 8'h00); wr(4'd12, 8'h01); wr(4'd6, 8'h80);
        apply(8'h08);
        check("R6 line D unchanged", 24'h080800);
        apply(8'h10);
        check("R6 line E unchanged", 24'h100008);
        apply(8'h00);

        // R7: SCI onto default pin 9
        @(negedge clk) sci_in = 1'b1;
        settle();
        check("R10 SCI latched, not yet out", 24'h0);
        settle();
        check("R7 SCI on GSI 9", 24'h000200);

        // R9: move while asserted
        wr(4'd4, 8'h01);
        check("R9 old pin held at write edge", 24'h000200);
        settle();
        check("R9 gap cycle, no pin", 24'h0);
        settle();
        check("R9 SCI on new pin 10", 24'h000400);

        // R8: reserved codes
        wr(4'd4, 8'h03); settle();
        check("R8 code 3 keeps pin 10", 24'h000400);
        wr(4'd4, 8'h07); settle(); settle();
        check("R8 code 7 keeps pin 10", 24'h000400);

        // R7 R9: move to an APIC pin
        wr(4'd4, 8'h04); settle(); settle();
        check("R7 R9 SCI on GSI 20", 24'h100000);

        @(negedge clk) sci_in = 1'b0;
        settle(); settle();
        check("R7 SCI dropped", 24'h0);

        // R7: retarget while low, then raise
        wr(4'd4, 8'h02);
        @(negedge clk) sci_in = 1'b1;
        settle(); settle();
        check("R7 SCI on GSI 11", 24'h000800);
        wr(4'd4, 8'h05); settle(); settle();
        check("R7 SCI on GSI 21", 24'h200000);

        // R1: mid-run reset restores defaults
        @(negedge clk) rst_n = 1'b0; sci_in = 1'b0;
        settle();
        check("R1 gsi cleared by reset", 24'h0);
        @(negedge clk) rst_n = 1'b1;
        apply(8'hFF);
        check("R1 routes back to disabled", 24'hFF0000);
        apply(8'h00);
        @(negedge clk) sci_in = 1'b1;
        settle(); settle();
        check("R1 SCI target back to 9", 24'h000200);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule